// File: doc/BRIEF.md
# Level Interrupt Controller with Priority Helpers

This block gathers up to 32 interrupt levels into one pending word. It gates that word with an enable word that software writes, and it raises a single interrupt line while any enabled level is pending. The gated word is readable, so the handler can see at once which enabled levels are active. Some levels have an external pin. Each such pin can act as a level-sensitive request, as an edge-triggered request with a sticky pending bit, as a general-purpose input or as a general-purpose output. The remaining levels take on-chip request lines, which are level-sensitive.

Priority is not fixed in hardware. Two helpers are offered instead. The first is a leading-zero count of the gated word. Level 0 sits in the most significant bit, so this count is directly the number of the most urgent active level. The second is a resolver with four programmable group masks. It returns the active levels of the first group, in mask order, that has any of them. Software can rewrite the masks at run time to change priorities.

Access is through a plain register port. Reads return data one cycle after the read strobe, and writes take effect at the clock edge that samples them. There is no back-pressure on either side: every access completes in a fixed time, so no valid/ready handshake is used.

Top module: `irqc_top`

## Requirements
- R1: The status word (address 2) equals the pending word (address 1) ANDed bitwise with the enable word (address 0, read/write). Level L occupies bit 31-L of every word, and on-chip request line `req_i` bit 31-L drives level L one clock later.
- R2: `irq_o` is high exactly when the status word has any bit set.
- R3: With its mode field at 00 (level), pin p (level p, bit 31-p) passes through a two-flop synchroniser. It is pending on the third clock edge after it changes and follows the pin from then on.
- R4: With mode 01 (edge), a rising pin edge sets the pending bit on the third edge. The bit then stays set after the pin falls, until software writes a 1 to that bit of address 1. Writing 0 leaves it set. Writing 1 to a bit whose level is not edge-latched has no effect. If a new edge and a clear arrive in the same cycle, the edge wins.
- R5: With mode 10 (general input) or 11 (general output), the pin never sets its pending bit. The synchronised pins read at address 6, with pin p at bit p.
- R6: In mode 11, `gpio_oe_o[p]` is high and `gpio_o[p]` drives bit p of the output data register (address 5). In any other mode both are low.
- R7: The mode register (address 4) holds 2 bits per pin, with pin p at bits 2p+1:2p.
- R8: Address 3 reads the count of leading zeros of the status word, which is the number of the most urgent active level. It reads 32 when the status word is zero.
- R9: The group result (address 7) is the status word ANDed with the first of masks 0..3 (addresses 12..15) that gives a non-zero result. Address 8 reads bit 31 = found and bits 1:0 = the index of that mask. When no mask matches, both addresses read 0.
- R10: Rewriting a mask changes the group result from the next read on, with no other action.
- R11: After reset, every register reads 0, all modes are level, `irq_o` and `gpio_oe_o` are low, and address 3 reads 32.
- R12: Read data appears on `bus_rdata_o` one clock after `bus_re_i` is sampled and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_we_i | input | 1 | Register write strobe |
| bus_re_i | input | 1 | Register read strobe |
| bus_addr_i | input | 4 | Register word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, registered |
| req_i | input | 32 | On-chip level requests, level L on bit 31-L |
| pin_i | input | 8 | External pins, asynchronous |
| gpio_o | output | 8 | General output data per pin |
| gpio_oe_o | output | 8 | Output enable per pin |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its defaults: 32 levels, 8 pins and 4 group masks. These values make a full-width status word reachable, so the leading-zero counter is exercised at both ends (0 and 32) as well as in between. They also give enough masks to show first-match order and a run-time reorder. With 8 pins, separate pins can be held in the level, edge, input and output modes at once, so their independence and the shared pending word can be observed through the register port.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  typedef enum logic [1:0] {
    PM_LEVEL = 2'b00,
    PM_EDGE  = 2'b01,
    PM_GPI   = 2'b10,
    PM_GPO   = 2'b11
  } pin_mode_e;

  localparam int unsigned REG_AW    = 4;
  localparam int unsigned MASK_BASE = 12;

  typedef enum logic [REG_AW-1:0] {
    RA_ENABLE = 4'd0,
    RA_PEND   = 4'd1,
    RA_STATUS = 4'd2,
    RA_LZC    = 4'd3,
    RA_MODE   = 4'd4,
    RA_GPO    = 4'd5,
    RA_GPI    = 4'd6,
    RA_GSET   = 4'd7,
    RA_GINFO  = 4'd8
  } reg_addr_e;

endpackage

// File: rtl/irqc_pin_cell.sv
module irqc_pin_cell
  import irqc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      pin_i,
  input  pin_mode_e mode_i,
  input  logic      clr_i,
  input  logic      req_i,
  output logic      sync_o,
  output logic      edge_hold_o,
  output logic      pend_o
);

  logic meta_q, sync_q, prev_q;
  logic hold_q, hold_d;
  logic pend_q, pend_d;
  logic rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise = sync_q & ~prev_q;

  always_comb begin
    hold_d = 1'b0;
    if (mode_i == PM_EDGE) hold_d = rise | (hold_q & ~clr_i);
  end

  always_comb begin
    unique case (mode_i)
      PM_LEVEL: pend_d = sync_q | req_i;
      PM_EDGE:  pend_d = hold_d | req_i;
      default:  pend_d = req_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      hold_q <= hold_d;
      pend_q <= pend_d;
    end
  end

  assign sync_o      = sync_q;
  assign edge_hold_o = hold_q;
  assign pend_o      = pend_q;

endmodule

// File: rtl/irqc_lzc.sv
module irqc_lzc #(
  parameter int unsigned W  = 32,
  localparam int unsigned CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);

  always_comb begin
    cnt_o = CW'(W);
    for (int i = 0; i < int'(W); i++) begin
      if (vec_i[i]) cnt_o = CW'(int'(W) - 1 - i);
    end
  end

endmodule

// File: rtl/irqc_grp_resolver.sv
module irqc_grp_resolver #(
  parameter int unsigned W  = 32,
  parameter int unsigned NG = 4,
  localparam int unsigned GW = (NG > 1) ? $clog2(NG) : 1
) (
  input  logic [NG-1:0][W-1:0] masks_i,
  input  logic [W-1:0]         status_i,
  output logic [W-1:0]         set_o,
  output logic [GW-1:0]        idx_o,
  output logic                 valid_o
);

  logic [NG-1:0][W-1:0] hit_word;
  logic [NG-1:0]        hit;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    assign hit_word[g] = masks_i[g] & status_i;
    assign hit[g]      = |hit_word[g];
  end

  always_comb begin
    set_o   = '0;
    idx_o   = '0;
    valid_o = 1'b0;
    for (int g = int'(NG) - 1; g >= 0; g--) begin
      if (hit[g]) begin
        set_o   = hit_word[g];
        idx_o   = GW'(g);
        valid_o = 1'b1;
      end
    end
  end

endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int unsigned NLVL = 32,
  parameter int unsigned NPIN = 8,
  parameter int unsigned NG   = 4,
  localparam int unsigned CW  = $clog2(NLVL + 1),
  localparam int unsigned GW  = (NG > 1) ? $clog2(NG) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic              bus_re_i,
  input  logic [REG_AW-1:0] bus_addr_i,
  input  logic [NLVL-1:0]   bus_wdata_i,
  output logic [NLVL-1:0]   bus_rdata_o,
  input  logic [NLVL-1:0]   req_i,
  input  logic [NPIN-1:0]   pin_i,
  output logic [NPIN-1:0]   gpio_o,
  output logic [NPIN-1:0]   gpio_oe_o,
  output logic              irq_o
);

  logic [NLVL-1:0]           en_q;
  pin_mode_e                 mode_q [NPIN];
  logic [NPIN-1:0]           gpo_q;
  logic [NG-1:0][NLVL-1:0]   mask_q;
  logic [NLVL-1:0]           pend;
  logic [NLVL-1:0]           status;
  logic [NPIN-1:0]           pin_sync;
  logic [NPIN-1:0]           edge_hold;
  logic [NPIN-1:0]           pin_clr;
  logic [2*NPIN-1:0]         mode_flat;
  logic [CW-1:0]             lzc;
  logic [NLVL-1:0]           grp_set;
  logic [GW-1:0]             grp_idx;
  logic                      grp_valid;
  logic [NLVL-1:0]           rdata_q;
  logic                      wr_pend;

  assign wr_pend = bus_we_i && (bus_addr_i == RA_PEND);

  // pending word: pin-backed levels first, on-chip only levels after
  for (genvar l = 0; l < NLVL; l++) begin : g_lvl
    localparam int unsigned B = NLVL - 1 - l;
    if (l < NPIN) begin : g_pin
      assign pin_clr[l] = wr_pend & bus_wdata_i[B];
      irqc_pin_cell u_cell (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .pin_i       (pin_i[l]),
        .mode_i      (mode_q[l]),
        .clr_i       (pin_clr[l]),
        .req_i       (req_i[B]),
        .sync_o      (pin_sync[l]),
        .edge_hold_o (edge_hold[l]),
        .pend_o      (pend[B])
      );
    end else begin : g_req
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pend[B] <= 1'b0;
        else         pend[B] <= req_i[B];
      end
    end
  end

  assign status = pend & en_q;
  assign irq_o  = |status;

  irqc_lzc #(.W(NLVL)) u_lzc (
    .vec_i (status),
    .cnt_o (lzc)
  );

  irqc_grp_resolver #(.W(NLVL), .NG(NG)) u_grp (
    .masks_i  (mask_q),
    .status_i (status),
    .set_o    (grp_set),
    .idx_o    (grp_idx),
    .valid_o  (grp_valid)
  );

  // configuration registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      gpo_q  <= '0;
      mask_q <= '0;
      for (int p = 0; p < int'(NPIN); p++) mode_q[p] <= PM_LEVEL;
    end else if (bus_we_i) begin
      if (bus_addr_i == RA_ENABLE) en_q <= bus_wdata_i;
      if (bus_addr_i == RA_GPO)    gpo_q <= bus_wdata_i[NPIN-1:0];
      if (bus_addr_i == RA_MODE) begin
        for (int p = 0; p < int'(NPIN); p++)
          mode_q[p] <= pin_mode_e'(bus_wdata_i[2*p +: 2]);
      end
      for (int g = 0; g < int'(NG); g++) begin
        if (bus_addr_i == REG_AW'(MASK_BASE + g)) mask_q[g] <= bus_wdata_i;
      end
    end
  end

  always_comb begin
    for (int p = 0; p < int'(NPIN); p++) mode_flat[2*p +: 2] = mode_q[p];
  end

  for (genvar p = 0; p < NPIN; p++) begin : g_gpio
    assign gpio_oe_o[p] = (mode_q[p] == PM_GPO);
    assign gpio_o[p]    = gpo_q[p] & gpio_oe_o[p];
  end

  // registered read port
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (bus_re_i) begin
      rdata_q <= '0;
      case (bus_addr_i)
        RA_ENABLE: rdata_q <= en_q;
        RA_PEND:   rdata_q <= pend;
        RA_STATUS: rdata_q <= status;
        RA_LZC:    rdata_q <= NLVL'(lzc);
        RA_MODE:   rdata_q <= NLVL'(mode_flat);
        RA_GPO:    rdata_q <= NLVL'(gpo_q);
        RA_GPI:    rdata_q <= NLVL'(pin_sync);
        RA_GSET:   rdata_q <= grp_set;
        RA_GINFO:  rdata_q <= {grp_valid, {(NLVL-1-GW){1'b0}}, grp_idx};
        default: begin
          for (int g = 0; g < int'(NG); g++) begin
            if (bus_addr_i == REG_AW'(MASK_BASE + g)) rdata_q <= mask_q[g];
          end
        end
      endcase
    end
  end

  assign bus_rdata_o = rdata_q;

endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int unsigned NLVL = 32,
  parameter int unsigned NPIN = 8,
  parameter int unsigned CW   = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              irq_o,
  input logic [CW-1:0]     lzc,
  input logic [NLVL-1:0]   status,
  input logic [NLVL-1:0]   pend,
  input logic [NLVL-1:0]   grp_set,
  input logic              grp_valid,
  input logic [NPIN-1:0]   edge_hold,
  input logic [2*NPIN-1:0] mode_flat,
  input logic              bus_we_i,
  input logic [NLVL-1:0]   req_i
);

  a_r2_irq_vs_lzc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (lzc != CW'(NLVL)));

  a_r8_lzc_points_to_set_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lzc < CW'(NLVL)) |-> status[NLVL - 1 - int'(lzc)]);

  a_r9_empty_when_no_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !grp_valid |-> (grp_set == '0));

  a_r9_set_within_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grp_set & ~status) == '0);

  a_r9_found_implies_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_valid |-> irq_o);

  for (genvar p = 0; p < NPIN; p++) begin : g_pin_chk
    a_r4_edge_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!bus_we_i && edge_hold[p]) |=> edge_hold[p]);

    a_r5_gpio_never_pends: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!bus_we_i && mode_flat[2*p+1] && !req_i[NLVL-1-p]) |=> !pend[NLVL-1-p]);
  end

endmodule

bind irqc_top irqc_chk #(.NLVL(NLVL), .NPIN(NPIN), .CW(CW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .irq_o     (irq_o),
  .lzc       (lzc),
  .status    (status),
  .pend      (pend),
  .grp_set   (grp_set),
  .grp_valid (grp_valid),
  .edge_hold (edge_hold),
  .mode_flat (mode_flat),
  .bus_we_i  (bus_we_i),
  .req_i     (req_i)
);

// File: tb/irqc_top_tb.sv
module irqc_top_tb;

  localparam int NLVL = 32;
  localparam int NPIN = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            we = 1'b0, re = 1'b0;
  logic [3:0]      addr = '0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata;
  logic [31:0]     req = '0;
  logic [NPIN-1:0] pins = '0;
  logic [NPIN-1:0] gpo, gpo_oe;
  logic            irq;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  irqc_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_re_i(re),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .req_i(req), .pin_i(pins), .gpio_o(gpo), .gpio_oe_o(gpo_oe), .irq_o(irq)
  );

  // stimulus table: {on-chip requests, enable word}
  localparam int NV = 8;
  localparam logic [63:0] VEC [NV] = '{
    {32'hFFFF_FFFF, 32'h0000_0001},
    {32'h8000_0000, 32'hFFFF_FFFF},
    {32'h0000_0000, 32'hFFFF_FFFF},
    {32'h0F0F_0000, 32'hFFFF_FFFF},
    {32'h00FF_0000, 32'h00F0_0000},
    {32'h1234_5678, 32'hFFFF_0000},
    {32'h0000_FFFF, 32'h0000_FFFF},
    {32'hAAAA_AAAA, 32'h5555_5555}
  };

  logic [31:0] masks [4] = '{32'hF000_0000, 32'h0F00_0000, 32'h00FF_0000, 32'h0000_FFFF};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); re = 1'b1; addr = a;
    @(negedge clk); re = 1'b0; d = rdata;
  endtask

  function automatic logic [31:0] m_clz(input logic [31:0] v);
    for (int i = 31; i >= 0; i--) if (v[i]) return 32'(31 - i);
    return 32'd32;
  endfunction

  function automatic logic [31:0] m_gset(input logic [31:0] st);
    for (int k = 0; k < 4; k++) if ((masks[k] & st) != 0) return masks[k] & st;
    return 32'd0;
  endfunction

  function automatic logic [31:0] m_ginfo(input logic [31:0] st);
    for (int k = 0; k < 4; k++) if ((masks[k] & st) != 0) return 32'h8000_0000 | 32'(k);
    return 32'd0;
  endfunction

  initial begin : watchdog
    #(8 * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] d, st;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    check("R11 irq after reset", 32'(irq), 32'd0);
    check("R11 oe after reset", 32'(gpo_oe), 32'd0);
    rd(4'd0, d);  check("R11 enable reset", d, 32'd0);
    rd(4'd1, d);  check("R11 pend reset", d, 32'd0);
    rd(4'd4, d);  check("R11 mode reset", d, 32'd0);
    rd(4'd3, d);  check("R11 lzc reset", d, 32'd32);
    rd(4'd8, d);  check("R11 ginfo reset", d, 32'd0);

    for (int k = 0; k < 4; k++) wr(4'(12 + k), masks[k]);
    rd(4'd13, d); check("R12 mask readback", d, masks[1]);

    // table walk: R1 R2 R8 R9
    for (int v = 0; v < NV; v++) begin
      req = VEC[v][63:32];
      wr(4'd0, VEC[v][31:0]);
      st = VEC[v][63:32] & VEC[v][31:0];
      rd(4'd2, d);  check($sformatf("R1 status vec%0d", v), d, st);
      check($sformatf("R2 irq vec%0d", v), 32'(irq), 32'(st != 0));
      rd(4'd3, d);  check($sformatf("R8 lzc vec%0d", v), d, m_clz(st));
      rd(4'd7, d);  check($sformatf("R9 gset vec%0d", v), d, m_gset(st));
      rd(4'd8, d);  check($sformatf("R9 ginfo vec%0d", v), d, m_ginfo(st));
    end

    // R3 level pin latency
    req = '0;
    wr(4'd0, 32'hFFFF_FFFF);
    @(negedge clk); pins[2] = 1'b1;
    repeat (2) @(negedge clk);
    check("R3 not yet pending after 2 edges", 32'(irq), 32'd0);
    @(negedge clk);
    check("R3 pending after 3 edges", 32'(irq), 32'd1);
    rd(4'd1, d);  check("R3 pend bit of level 2", d, 32'h2000_0000);
    pins[2] = 1'b0;
    repeat (4) @(negedge clk);
    check("R3 follows pin low", 32'(irq), 32'd0);

    // R4 edge pin 3, R7 field position
    wr(4'd4, 32'h0000_0040);
    rd(4'd4, d);  check("R7 mode readback", d, 32'h0000_0040);
    @(negedge clk); pins[3] = 1'b1;
    repeat (4) @(negedge clk); pins[3] = 1'b0;
    repeat (4) @(negedge clk);
    rd(4'd1, d);  check("R4 sticky after pin fall", d, 32'h1000_0000);
    wr(4'd1, 32'h0000_0000);
    rd(4'd1, d);  check("R4 write 0 keeps bit", d, 32'h1000_0000);
    wr(4'd1, 32'h1000_0000);
    rd(4'd1, d);  check("R4 write 1 clears", d, 32'h0000_0000);
    check("R4 irq after clear", 32'(irq), 32'd0);
    req = 32'h0010_0000;
    repeat (2) @(negedge clk);
    wr(4'd1, 32'h0010_0000);
    rd(4'd1, d);  check("R4 clear ignored on level bit", d, 32'h0010_0000);
    req = '0;

    // R5 general input, R6 general output
    wr(4'd4, 32'h0000_0E00);
    @(negedge clk); pins[4] = 1'b1;
    repeat (4) @(negedge clk);
    rd(4'd1, d);  check("R5 gpi pin not pending", d, 32'd0);
    check("R5 irq stays low", 32'(irq), 32'd0);
    rd(4'd6, d);  check("R5 gpi readback", d, 32'h0000_0010);
    wr(4'd5, 32'h0000_00FF);
    check("R6 gpio_o only on output pin", 32'(gpo), 32'h0000_0020);
    check("R6 oe only on output pin", 32'(gpo_oe), 32'h0000_0020);
    pins[4] = 1'b0;

    // R10 run-time mask reorder
    req = 32'h1000_0001;
    wr(4'd0, 32'hFFFF_FFFF);
    rd(4'd7, d);  check("R10 group before rewrite", d, 32'h1000_0000);
    masks[0] = 32'h0000_000F;
    wr(4'd12, masks[0]);
    rd(4'd7, d);  check("R10 group after rewrite", d, 32'h0000_0001);
    rd(4'd8, d);  check("R10 ginfo after rewrite", d, 32'h8000_0000);
    for (int k = 0; k < 4; k++) begin
      masks[k] = '0;
      wr(4'(12 + k), 32'd0);
    end
    rd(4'd8, d);  check("R9 no match ginfo", d, 32'd0);
    rd(4'd7, d);  check("R9 no match gset", d, 32'd0);

    // R12 read data holds without strobe
    repeat (3) @(negedge clk);
    check("R12 rdata held", rdata, 32'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule